// File: doc/BRIEF.md
# Filter branch and PC update unit

This unit resolves the jump class of a packet-filter processor. Each accepted instruction carries its byte program counter, a 4-bit jump code, a flag that selects a 32-bit or a 64-bit compare, two operands, a signed 16-bit slot offset and a flag that marks a double-width instruction. One cycle later the unit presents the next program counter and a taken flag. Conditional targets are counted in 8-byte instruction slots from the instruction that follows. Signed and unsigned compares share one code space.

Service requests leave the program counter alone. A service call raises a one-cycle call strobe that carries the 32-bit call target. A program end raises a one-cycle exit strobe. In both cases the unit stays busy until the surrounding core returns an acknowledge. Three states drive this: `ST_IDLE` accepts instructions, `ST_CALL_WAIT` holds after a call, and `ST_EXIT_WAIT` holds after an exit. There are four transitions. IDLE goes to CALL_WAIT when a call code is accepted, and to EXIT_WAIT when an exit code is accepted. CALL_WAIT returns to IDLE on acknowledge and then publishes the resume address. EXIT_WAIT returns to IDLE on acknowledge and publishes nothing.

Top module: `fbr_branch_unit`

## Requirements
- R1: After reset, `pc_valid`, `taken`, `call_stb`, `exit_stb` and `busy` are 0, and `next_pc` is 0.
- R2: An instruction is accepted on a clock edge where `in_valid` is 1 and `busy` is 0. The codes used are: always-jump 0, equal 1, unsigned greater 2, unsigned greater-or-equal 3, bit-test 4, not-equal 5, signed greater 6, signed greater-or-equal 7, call 8, exit 9, unsigned less 0xA, unsigned less-or-equal 0xB, signed less 0xC, signed less-or-equal 0xD. For every code except 8 and 9, `pc_valid` is 1 for exactly the following cycle, and `taken` shows the outcome in that cycle.
- R3: A taken branch sets `next_pc` to pc + (offset + 1) * 8, where offset is sign-extended from 16 bits.
- R4: A branch that is not taken sets `next_pc` to pc + 8, or to pc + 16 when `wide_insn` is 1.
- R5: Codes 2, 3, 0xA and 0xB compare operand A against operand B as unsigned numbers.
- R6: Codes 6, 7, 0xC and 0xD compare as two's-complement signed numbers.
- R7: Code 1 is taken when the operands are equal. Code 5 is taken when they differ. Code 4 is taken when the bitwise AND of the operands is nonzero.
- R8: With `cmp_narrow` at 1, every compare uses only bits 31:0 of both operands, and bit 31 is the sign for the signed codes. With `cmp_narrow` at 0, all 64 bits are used.
- R9: Code 0 is always taken, whatever the operands and the compare width, and its target follows R3 even when `wide_insn` is 1.
- R10: Code 8 raises `call_stb` for one cycle with `call_target` equal to operand B bits 31:0, and `pc_valid` stays 0. An acknowledge in `ST_CALL_WAIT` then produces a single `pc_valid` cycle with `taken` at 0 and `next_pc` at the fall-through address of R4.
- R11: Code 9 raises `exit_stb` for one cycle. The acknowledge that follows returns the unit to idle without a `pc_valid` cycle and without changing `next_pc`.
- R12: While `busy` is 1, `in_valid` is ignored. While the unit is idle, `svc_ack` is ignored. Neither produces `pc_valid` or a change of `next_pc`.
- R13: Codes 0xE and 0xF are never taken and follow the fall-through rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Jump-class instruction present |
| pc_in | input | 64 | Byte address of the instruction |
| op_code | input | 4 | Jump code |
| cmp_narrow | input | 1 | 1: compare low 32 bits only |
| opnd_a | input | 64 | Destination register value |
| opnd_b | input | 64 | Source register or sign-extended immediate |
| offset | input | 16 | Signed slot displacement |
| wide_insn | input | 1 | Current instruction is double width |
| svc_ack | input | 1 | Core finished the call or exit |
| next_pc | output | 64 | Next program counter |
| pc_valid | output | 1 | `next_pc` updated this cycle |
| taken | output | 1 | Branch taken (qualified by `pc_valid`) |
| call_stb | output | 1 | One-cycle call request |
| exit_stb | output | 1 | One-cycle exit request |
| call_target | output | 32 | Call target value |
| busy | output | 1 | Waiting for `svc_ack` |

## Verification
On every cycle the assertions check four things: the result, call and exit events never coincide; the strobes last one cycle; a waiting state without acknowledge neither publishes nor moves `next_pc`; and always-jump and fall-through results take the addresses computed one edge earlier. The bench scenarios are what show the compare semantics: unsigned against signed on the same operands, the narrow mode hiding upper bits and moving the sign to bit 31, and bit-test. They also show the extreme offsets, the call resume address, the exit that leaves `next_pc` untouched, and stimulus being ignored while busy.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] OP_JA   = 4'h0;
    localparam logic [CODE_W-1:0] OP_JEQ  = 4'h1;
    localparam logic [CODE_W-1:0] OP_JGT  = 4'h2;
    localparam logic [CODE_W-1:0] OP_JGE  = 4'h3;
    localparam logic [CODE_W-1:0] OP_JSET = 4'h4;
    localparam logic [CODE_W-1:0] OP_JNE  = 4'h5;
    localparam logic [CODE_W-1:0] OP_JSGT = 4'h6;
    localparam logic [CODE_W-1:0] OP_JSGE = 4'h7;
    localparam logic [CODE_W-1:0] OP_CALL = 4'h8;
    localparam logic [CODE_W-1:0] OP_EXIT = 4'h9;
    localparam logic [CODE_W-1:0] OP_JLT  = 4'hA;
    localparam logic [CODE_W-1:0] OP_JLE  = 4'hB;
    localparam logic [CODE_W-1:0] OP_JSLT = 4'hC;
    localparam logic [CODE_W-1:0] OP_JSLE = 4'hD;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_CALL_WAIT = 2'd1,
        ST_EXIT_WAIT = 2'd2
    } fbr_state_e;
endpackage

// File: rtl/fbr_cond_eval.sv
module fbr_cond_eval
    import fbr_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [CODE_W-1:0] op,
    input  logic              narrow,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              cond_taken
);
    localparam int EXT_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] a_u, b_u, a_s, b_s;
    logic              eq, ltu, lts, any_set;

    // Zero-extended view for unsigned and equality tests, sign-extended view for signed tests
    always_comb begin
        if (narrow) begin
            a_u = {{EXT_W{1'b0}}, a[NARROW_W-1:0]};
            b_u = {{EXT_W{1'b0}}, b[NARROW_W-1:0]};
            a_s = {{EXT_W{a[NARROW_W-1]}}, a[NARROW_W-1:0]};
            b_s = {{EXT_W{b[NARROW_W-1]}}, b[NARROW_W-1:0]};
        end else begin
            a_u = a;
            b_u = b;
            a_s = a;
            b_s = b;
        end
    end

    assign eq      = (a_u == b_u);
    assign ltu     = (a_u < b_u);
    assign lts     = ($signed(a_s) < $signed(b_s));
    assign any_set = |(a_u & b_u);

    always_comb begin
        case (op)
            OP_JA:   cond_taken = 1'b1;
            OP_JEQ:  cond_taken = eq;
            OP_JNE:  cond_taken = !eq;
            OP_JSET: cond_taken = any_set;
            OP_JGT:  cond_taken = !ltu && !eq;
            OP_JGE:  cond_taken = !ltu;
            OP_JLT:  cond_taken = ltu;
            OP_JLE:  cond_taken = ltu || eq;
            OP_JSGT: cond_taken = !lts && !eq;
            OP_JSGE: cond_taken = !lts;
            OP_JSLT: cond_taken = lts;
            OP_JSLE: cond_taken = lts || eq;
            default: cond_taken = 1'b0;   // call, exit and unused codes 0xE/0xF
        endcase
    end
endmodule

// File: rtl/fbr_target_calc.sv
module fbr_target_calc #(
    parameter int PC_W       = 64,
    parameter int OFF_W      = 16,
    parameter int SLOT_SHIFT = 3
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic             wide,
    output logic [PC_W-1:0]  taken_pc,
    output logic [PC_W-1:0]  fall_pc
);
    localparam int               EXT_W = PC_W - OFF_W;
    localparam logic [PC_W-1:0]  ONE   = PC_W'(1);
    localparam logic [PC_W-1:0]  TWO   = PC_W'(2);

    logic [PC_W-1:0] off_ext, slots;

    // Displacement is relative to the following slot, so add one slot before scaling
    assign off_ext  = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign slots    = off_ext + ONE;
    assign taken_pc = pc + (slots << SLOT_SHIFT);
    assign fall_pc  = pc + ((wide ? TWO : ONE) << SLOT_SHIFT);
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
    import fbr_pkg::*;
#(
    parameter int PC_W   = 64,
    parameter int CALL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] op,
    input  logic              cond_taken,
    input  logic [PC_W-1:0]   taken_pc,
    input  logic [PC_W-1:0]   fall_pc,
    input  logic [CALL_W-1:0] call_imm,
    input  logic              ack,
    output logic [PC_W-1:0]   next_pc_q,
    output logic              pc_valid_q,
    output logic              taken_q,
    output logic              call_stb_q,
    output logic              exit_stb_q,
    output logic [CALL_W-1:0] call_target_q,
    output logic              busy
);
    fbr_state_e      state_q, state_d;
    logic [PC_W-1:0] resume_q;
    logic            accept, is_call, is_exit;

    assign accept  = in_valid && (state_q == ST_IDLE);
    assign is_call = (op == OP_CALL);
    assign is_exit = (op == OP_EXIT);
    assign busy    = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_call)      state_d = ST_CALL_WAIT;
                else if (accept && is_exit) state_d = ST_EXIT_WAIT;
            end
            ST_CALL_WAIT: if (ack) state_d = ST_IDLE;
            ST_EXIT_WAIT: if (ack) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_q     <= '0;
            pc_valid_q    <= 1'b0;
            taken_q       <= 1'b0;
            call_stb_q    <= 1'b0;
            exit_stb_q    <= 1'b0;
            call_target_q <= '0;
            resume_q      <= '0;
        end else begin
            pc_valid_q <= 1'b0;
            taken_q    <= 1'b0;
            call_stb_q <= 1'b0;
            exit_stb_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (is_call) begin
                            call_stb_q    <= 1'b1;
                            call_target_q <= call_imm;
                            resume_q      <= fall_pc;
                        end else if (is_exit) begin
                            exit_stb_q <= 1'b1;
                        end else begin
                            pc_valid_q <= 1'b1;
                            taken_q    <= cond_taken;
                            next_pc_q  <= cond_taken ? taken_pc : fall_pc;
                        end
                    end
                end
                ST_CALL_WAIT: begin
                    if (ack) begin
                        pc_valid_q <= 1'b1;
                        next_pc_q  <= resume_q;
                    end
                end
                ST_EXIT_WAIT: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R10 / R11: result, call and exit events are mutually exclusive
    p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_valid_q, call_stb_q, exit_stb_q}));

    // R10: call strobe lasts a single cycle
    p_call_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        call_stb_q |=> !call_stb_q);

    // R11: exit strobe lasts a single cycle and the exit wait never publishes a PC
    p_exit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exit_stb_q |=> !exit_stb_q);
    p_exit_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT_WAIT) |=> !pc_valid_q);

    // R12: a waiting state without acknowledge holds the program counter
    p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack) |=> (!pc_valid_q && $stable(next_pc_q)));

    // R9: always-jump publishes the taken target
    p_ja_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_JA) |=> (pc_valid_q && taken_q && next_pc_q == $past(taken_pc)));

    // R4: a not-taken result from idle lands on the fall-through address
    p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_call && !is_exit && !cond_taken) |=> (pc_valid_q && !taken_q && next_pc_q == $past(fall_pc)));
endmodule

// File: rtl/fbr_branch_unit.sv
module fbr_branch_unit
    import fbr_pkg::*;
#(
    parameter int PC_W       = 64,
    parameter int DATA_W     = 64,
    parameter int NARROW_W   = 32,
    parameter int OFF_W      = 16,
    parameter int CALL_W     = 32,
    parameter int SLOT_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [3:0]        op_code,
    input  logic              cmp_narrow,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [OFF_W-1:0]  offset,
    input  logic              wide_insn,
    input  logic              svc_ack,
    output logic [PC_W-1:0]   next_pc,
    output logic              pc_valid,
    output logic              taken,
    output logic              call_stb,
    output logic              exit_stb,
    output logic [CALL_W-1:0] call_target,
    output logic              busy
);
    logic            cond_taken;
    logic [PC_W-1:0] taken_pc, fall_pc;

    fbr_cond_eval #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_cond (
        .op         (op_code),
        .narrow     (cmp_narrow),
        .a          (opnd_a),
        .b          (opnd_b),
        .cond_taken (cond_taken)
    );

    fbr_target_calc #(
        .PC_W       (PC_W),
        .OFF_W      (OFF_W),
        .SLOT_SHIFT (SLOT_SHIFT)
    ) u_target (
        .pc       (pc_in),
        .offset   (offset),
        .wide     (wide_insn),
        .taken_pc (taken_pc),
        .fall_pc  (fall_pc)
    );

    fbr_seq #(
        .PC_W   (PC_W),
        .CALL_W (CALL_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .op            (op_code),
        .cond_taken    (cond_taken),
        .taken_pc      (taken_pc),
        .fall_pc       (fall_pc),
        .call_imm      (opnd_b[CALL_W-1:0]),
        .ack           (svc_ack),
        .next_pc_q     (next_pc),
        .pc_valid_q    (pc_valid),
        .taken_q       (taken),
        .call_stb_q    (call_stb),
        .exit_stb_q    (exit_stb),
        .call_target_q (call_target),
        .busy          (busy)
    );
endmodule

// File: tb/fbr_branch_unit_bench.sv
module fbr_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] pc_in = '0;
    logic [3:0]  op_code = '0;
    logic        cmp_narrow = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [15:0] offset = '0;
    logic        wide_insn = 1'b0;
    logic        svc_ack = 1'b0;
    logic [63:0] next_pc;
    logic        pc_valid, taken, call_stb, exit_stb, busy;
    logic [31:0] call_target;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    fbr_branch_unit u_fbr_branch_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in),
        .op_code(op_code), .cmp_narrow(cmp_narrow), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .offset(offset), .wide_insn(wide_insn),
        .svc_ack(svc_ack), .next_pc(next_pc), .pc_valid(pc_valid),
        .taken(taken), .call_stb(call_stb), .exit_stb(exit_stb),
        .call_target(call_target), .busy(busy)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        nar;
        logic [63:0] a;
        logic [63:0] b;
        logic [15:0] off;
        logic        wide;
        logic        exp;
    } vec_t;

    localparam int NV = 25;
    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VECS [NV] = '{
        '{4'h1, 1'b0, 64'd5, 64'd5, 16'd3, 1'b0, 1'b1},                       // R7 eq
        '{4'h1, 1'b0, 64'd5, 64'd6, 16'd3, 1'b0, 1'b0},                       // R7 eq miss
        '{4'h5, 1'b0, 64'd5, 64'd6, 16'hFFFF, 1'b0, 1'b1},                    // R7 ne, R3 self
        '{4'h4, 1'b0, 64'hF0, 64'h0F, 16'd2, 1'b0, 1'b0},                     // R7 set miss
        '{4'h4, 1'b0, 64'hF0, 64'h10, 16'h7FFF, 1'b0, 1'b1},                  // R7 set, R3 max
        '{4'h2, 1'b0, M1, 64'd1, 16'h8000, 1'b0, 1'b1},                       // R5 gt, R3 min
        '{4'h6, 1'b0, M1, 64'd1, 16'd4, 1'b0, 1'b0},                          // R6 sgt
        '{4'hA, 1'b0, 64'd1, M1, 16'd4, 1'b0, 1'b1},                          // R5 lt
        '{4'hC, 1'b0, M1, 64'd1, 16'd4, 1'b0, 1'b1},                          // R6 slt
        '{4'h3, 1'b0, 64'd7, 64'd7, 16'd9, 1'b0, 1'b1},                       // R5 ge
        '{4'hB, 1'b0, 64'd8, 64'd7, 16'd9, 1'b0, 1'b0},                       // R5 le
        '{4'h7, 1'b0, 64'h8000_0000_0000_0000, 64'd0, 16'd1, 1'b0, 1'b0},     // R6 sge
        '{4'hD, 1'b0, 64'h8000_0000_0000_0000, 64'd0, 16'd1, 1'b0, 1'b1},     // R6 sle
        '{4'h1, 1'b1, 64'h1_0000_0005, 64'd5, 16'd6, 1'b0, 1'b1},             // R8 narrow eq
        '{4'h1, 1'b0, 64'h1_0000_0005, 64'd5, 16'd6, 1'b0, 1'b0},             // R8 wide eq
        '{4'h6, 1'b1, 64'h8000_0000, 64'd1, 16'd2, 1'b0, 1'b0},               // R8 narrow sgt
        '{4'h6, 1'b0, 64'h8000_0000, 64'd1, 16'd2, 1'b0, 1'b1},               // R8 wide sgt
        '{4'h2, 1'b1, 64'h8000_0000, 64'd1, 16'd2, 1'b0, 1'b1},               // R8 narrow gt
        '{4'h4, 1'b1, 64'h1_0000_0000, 64'h1_0000_0000, 16'd2, 1'b0, 1'b0},   // R8 narrow set
        '{4'h0, 1'b0, 64'd1, 64'd2, 16'd5, 1'b0, 1'b1},                       // R9 ja
        '{4'h0, 1'b1, 64'd0, 64'd0, 16'd0, 1'b1, 1'b1},                       // R9 ja wide
        '{4'hE, 1'b0, 64'd0, 64'd0, 16'd3, 1'b1, 1'b0},                       // R13 0xE
        '{4'hF, 1'b0, 64'd0, 64'd0, 16'd3, 1'b0, 1'b0},                       // R13 0xF
        '{4'h2, 1'b0, 64'd1, 64'd2, 16'd3, 1'b1, 1'b0},                       // R4 wide fall
        '{4'hA, 1'b1, 64'hFFFF_FFFF_0000_0001, 64'd2, 16'd3, 1'b0, 1'b1}      // R8 narrow lt
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_pc(input logic [63:0] pc, input logic [15:0] off,
                                           input logic wide, input logic tk);
        logic [63:0] s;
        s = {{48{off[15]}}, off} + 64'd1;
        return tk ? pc + s * 64'd8 : pc + (wide ? 64'd16 : 64'd8);
    endfunction

    task automatic issue(input logic [3:0] op, input logic nar, input logic [63:0] a,
                         input logic [63:0] b, input logic [15:0] off, input logic wide,
                         input logic [63:0] pc);
        in_valid = 1'b1; op_code = op; cmp_narrow = nar; opnd_a = a; opnd_b = b;
        offset = off; wide_insn = wide; pc_in = pc;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] pc, held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pc_valid == 0 && taken == 0, "R1 flags", {62'd0, pc_valid, taken}, 64'd0);
        chk(call_stb == 0 && exit_stb == 0 && busy == 0, "R1 strobes",
            {61'd0, call_stb, exit_stb, busy}, 64'd0);
        chk(next_pc == 0, "R1 next_pc", next_pc, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 ack while idle is ignored
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
        chk(pc_valid == 0 && busy == 0, "R12 idle ack", {62'd0, pc_valid, busy}, 64'd0);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9 R13
        for (int i = 0; i < NV; i++) begin
            pc = 64'h0010_0000 + 64'(i) * 64'h100;
            issue(VECS[i].op, VECS[i].nar, VECS[i].a, VECS[i].b, VECS[i].off, VECS[i].wide, pc);
            @(negedge clk);
            in_valid = 1'b0;
            chk(pc_valid == 1, $sformatf("R2 valid vec%0d", i), {63'd0, pc_valid}, 64'd1);
            chk(taken == VECS[i].exp, $sformatf("R2 taken vec%0d", i), {63'd0, taken}, {63'd0, VECS[i].exp});
            chk(next_pc == exp_pc(pc, VECS[i].off, VECS[i].wide, VECS[i].exp),
                $sformatf("R3/R4 next_pc vec%0d", i), next_pc,
                exp_pc(pc, VECS[i].off, VECS[i].wide, VECS[i].exp));
            @(negedge clk);
            chk(pc_valid == 0, $sformatf("R2 single pulse vec%0d", i), {63'd0, pc_valid}, 64'd0);
        end

        // R10 call
        issue(4'h8, 1'b0, 64'd0, 64'hFFFF_FFFF_1234_5678, 16'd0, 1'b0, 64'h2000);
        @(negedge clk);
        chk(call_stb == 1 && pc_valid == 0 && busy == 1, "R10 strobe",
            {61'd0, call_stb, pc_valid, busy}, 64'd5);
        chk(call_target == 32'h1234_5678, "R10 target", {32'd0, call_target}, 64'h1234_5678);
        // R12 new instruction while busy is ignored
        issue(4'h0, 1'b0, 64'd0, 64'd0, 16'd20, 1'b0, 64'h9000);
        @(negedge clk);
        in_valid = 1'b0;
        chk(call_stb == 0, "R10 one-cycle strobe", {63'd0, call_stb}, 64'd0);
        chk(pc_valid == 0 && busy == 1, "R12 busy ignore", {62'd0, pc_valid, busy}, 64'd1);
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
        chk(pc_valid == 1 && taken == 0 && busy == 0, "R10 resume",
            {61'd0, pc_valid, taken, busy}, 64'd4);
        chk(next_pc == 64'h2008, "R10 resume pc", next_pc, 64'h2008);
        held = next_pc;
        @(negedge clk);

        // R11 exit
        issue(4'h9, 1'b0, 64'd0, 64'd0, 16'd0, 1'b0, 64'h3000);
        @(negedge clk);
        in_valid = 1'b0;
        chk(exit_stb == 1 && pc_valid == 0 && busy == 1, "R11 strobe",
            {61'd0, exit_stb, pc_valid, busy}, 64'd5);
        @(negedge clk);
        chk(exit_stb == 0 && next_pc == held, "R11 hold", next_pc, held);
        svc_ack = 1'b1;
        @(negedge clk);
        svc_ack = 1'b0;
        chk(busy == 0 && pc_valid == 0, "R11 release", {62'd0, busy, pc_valid}, 64'd0);
        chk(next_pc == held, "R11 pc unchanged", next_pc, held);

        // R2 accepted again after exit
        issue(4'h1, 1'b0, 64'd9, 64'd9, 16'd1, 1'b0, 64'h4000);
        @(negedge clk);
        in_valid = 1'b0;
        chk(pc_valid == 1 && taken == 1 && next_pc == 64'h4010, "R2 after exit", next_pc, 64'h4010);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule